// File: doc/BRIEF.md
# Linked Descriptor DMA Walker

This block is one DMA channel that walks a chain of descriptors held in memory and moves 16-bit words between that memory and a peripheral word stream. Each descriptor is three 32-bit memory words: a control/length word, a buffer start address and the address of the next descriptor. Software loads the address of the first descriptor into the channel, picks a direction, and pulses a start command. The channel then reads the descriptor, moves its words, follows the next pointer on its own, and stops after the descriptor whose end-of-list flag is set.

The direction is taken at start. Outbound runs read each word from memory and offer it on the outbound stream. Inbound runs accept each word from the inbound stream and write it to memory. A run also ends when its total word count reaches the peripheral burst cap. An abort command drops the channel back to idle at once from any state. Software waits for the sticky idle flag before programming the channel again.

The memory port is a simple request/acknowledge port: the channel holds the request, address and write data until acknowledged, and read data is taken in the acknowledge cycle.

Top module: `dwk_walker`

## Requirements
- R1: After reset `chan_idle` is 1, `done_pulse` is 0, and `mem_req`, `pout_valid` and `pin_ready` are 0. While idle none of these three is raised.
- R2: After a start, the descriptor at pointer P is read as three words in a fixed order: P (control/length), P+4 (buffer address), P+8 (next pointer). No data word moves before the third read completes. In the control/length word, bits 15:0 hold the byte length and bit 16 is the end-of-list flag.
- R3: A byte length L (even) moves L/2 words. A length field of 0 moves 32768 words (65536 bytes), and the next descriptor is read only after all of them.
- R4: Outbound (`dir_to_mem`=0 at start): word k of a descriptor is read from buffer address B+2k and offered on `pout_data` as bits 15:0 of the read data, in order.
- R5: Inbound (`dir_to_mem`=1 at start): words accepted on the inbound stream are written in arrival order with `mem_we`=1 to addresses B+2k, with the word on `mem_wdata`.
- R6: When the last word of a descriptor without end-of-list has moved, the channel reads the descriptor at that descriptor's next pointer and continues without any software action.
- R7: When the last word of an end-of-list descriptor moves, `done_pulse` is 1 for exactly one cycle and `chan_idle` becomes 1. It stays 1 until the next accepted start, which clears it.
- R8: `cmd_abort` puts the channel in idle on the next cycle from any state. After that there are no further memory requests, stream transfers or done pulse.
- R9: The number of words moved in one run never exceeds `BURST_LIMIT`. When the cap is reached, the run ends with a done pulse, as if end-of-list had been seen.
- R10: A start while a run is active is ignored. A pointer write during a run does not change that run; the pointer takes effect at the next start.
- R11: Memory acknowledge delays and outbound back-pressure lose, repeat or reorder no word. A pending request and a stalled outbound word keep their address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr | input | 1 | Load strobe for the first-descriptor pointer |
| ptr_wdata | input | AW | First-descriptor pointer value |
| cmd_start | input | 1 | Start command pulse |
| cmd_abort | input | 1 | Abort command pulse |
| dir_to_mem | input | 1 | Direction taken at start: 1 stream to memory, 0 memory to stream |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| pout_valid | output | 1 | Outbound word valid |
| pout_data | output | 16 | Outbound word |
| pout_ready | input | 1 | Outbound word accepted |
| pin_valid | input | 1 | Inbound word valid |
| pin_data | input | 16 | Inbound word |
| pin_ready | output | 1 | Channel accepts an inbound word |
| chan_idle | output | 1 | Sticky idle status |
| done_pulse | output | 1 | One-cycle pulse at the end of a run |

## Verification
The walker is tried with a single short outbound descriptor, which pins down fetch order and the length-to-word count. A three-descriptor chain placed out of address order under a stalling memory and stalling outbound stream separates true pointer following from sequential fetching, and shows that stalls do not lose or repeat words. An inbound run checks write addresses against arrival order. An abort in the middle of a long descriptor, and a start and pointer rewrite during an active run, show that commands act only where they should. A zero-length descriptor chained to one that runs past the burst cap tells the 65536-byte encoding apart from an off-by-one, and shows that the cap ends the run in the middle of a descriptor.

// File: rtl/dwk_pkg.sv
package dwk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F_CTL,
    ST_F_BUF,
    ST_F_NXT,
    ST_MEM,
    ST_PER
  } dwk_state_t;

  localparam int LEN_W       = 16;   // byte length field width
  localparam int EOL_BIT     = 16;   // end-of-list flag inside control word
  localparam int WORD_BYTES  = 2;    // bytes moved per transfer
  localparam int DESC_STRIDE = 4;    // byte step between descriptor words

  // byte length to word count; an all-zero field stands for the full range
  function automatic logic [LEN_W-1:0] len_to_words(input logic [LEN_W-1:0] len);
    if (len == '0) return LEN_W'(1 << (LEN_W - 1));
    return len >> 1;
  endfunction

endpackage

// File: rtl/dwk_desc_regs.sv
module dwk_desc_regs
  import dwk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ld,
  input  logic [AW-1:0] first_ptr,
  input  logic          ld_ctl,
  input  logic          ld_buf,
  input  logic          ld_nxt,
  input  logic [31:0]   rdata,
  input  logic          word_done,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] buf_addr,
  output logic          eol,
  output logic          last_word
);

  logic [LEN_W-1:0] words_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr    <= '0;
      buf_addr   <= '0;
      eol        <= 1'b0;
      words_left <= '0;
    end else begin
      if (start_ld)    cur_ptr <= first_ptr;
      else if (ld_nxt) cur_ptr <= rdata[AW-1:0];

      if (ld_ctl) begin
        words_left <= len_to_words(rdata[LEN_W-1:0]);
        eol        <= rdata[EOL_BIT];
      end else if (word_done) begin
        words_left <= words_left - 1'b1;
      end

      if (ld_buf)         buf_addr <= rdata[AW-1:0];
      else if (word_done) buf_addr <= buf_addr + AW'(WORD_BYTES);
    end
  end

  assign last_word = (words_left == LEN_W'(1));

endmodule

// File: rtl/dwk_burst_cnt.sv
module dwk_burst_cnt #(
  parameter int LIMIT = 65536
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       inc,
  output logic [$clog2(LIMIT+1)-1:0] cnt,
  output logic                       at_cap_next
);

  localparam int CW = $clog2(LIMIT + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_cap_next = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/dwk_walker.sv
module dwk_walker
  import dwk_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BURST_LIMIT = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          cmd_start,
  input  logic          cmd_abort,
  input  logic          dir_to_mem,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          pout_valid,
  output logic [15:0]   pout_data,
  input  logic          pout_ready,
  input  logic          pin_valid,
  input  logic [15:0]   pin_data,
  output logic          pin_ready,
  output logic          chan_idle,
  output logic          done_pulse
);

  localparam int CW = $clog2(BURST_LIMIT + 1);

  dwk_state_t st, st_nx, first_data_st, after_word;
  logic [AW-1:0] first_ptr, cur_ptr, buf_addr;
  logic [15:0]   hold_word;
  logic          to_mem, eol, last_word, at_cap_next;
  logic [CW-1:0] burst_cnt;

  // named internal events
  logic start_acc, word_done, run_end, desc_end;
  logic ld_ctl, ld_buf, ld_nxt;

  assign start_acc = cmd_start && !cmd_abort && (st == ST_IDLE);
  assign ld_ctl    = (st == ST_F_CTL) && mem_ack;
  assign ld_buf    = (st == ST_F_BUF) && mem_ack;
  assign ld_nxt    = (st == ST_F_NXT) && mem_ack;
  assign word_done = ((st == ST_PER) && !to_mem && pout_ready) ||
                     ((st == ST_MEM) &&  to_mem && mem_ack);
  assign run_end   = word_done && (at_cap_next || (last_word && eol));
  assign desc_end  = word_done && last_word && !run_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_ptr <= '0;
    else if (ptr_wr) first_ptr <= ptr_wdata;
  end

  dwk_desc_regs #(.AW(AW)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ld  (start_acc),
    .first_ptr (first_ptr),
    .ld_ctl    (ld_ctl),
    .ld_buf    (ld_buf),
    .ld_nxt    (ld_nxt),
    .rdata     (mem_rdata),
    .word_done (word_done),
    .cur_ptr   (cur_ptr),
    .buf_addr  (buf_addr),
    .eol       (eol),
    .last_word (last_word)
  );

  dwk_burst_cnt #(.LIMIT(BURST_LIMIT)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (start_acc),
    .inc         (word_done),
    .cnt         (burst_cnt),
    .at_cap_next (at_cap_next)
  );

  // sequencing
  assign first_data_st = to_mem ? ST_PER : ST_MEM;
  assign after_word    = run_end ? ST_IDLE : (desc_end ? ST_F_CTL : first_data_st);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start_acc) st_nx = ST_F_CTL;
      ST_F_CTL: if (mem_ack)   st_nx = ST_F_BUF;
      ST_F_BUF: if (mem_ack)   st_nx = ST_F_NXT;
      ST_F_NXT: if (mem_ack)   st_nx = first_data_st;
      ST_MEM:   if (mem_ack)   st_nx = to_mem ? after_word : ST_PER;
      ST_PER:   if (to_mem ? pin_valid : pout_ready)
                  st_nx = to_mem ? ST_MEM : after_word;
      default:  st_nx = ST_IDLE;
    endcase
    if (cmd_abort) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      to_mem     <= 1'b0;
      hold_word  <= '0;
      chan_idle  <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      st         <= st_nx;
      done_pulse <= run_end && !cmd_abort;
      if (start_acc) to_mem <= dir_to_mem;
      if ((st == ST_MEM) && !to_mem && mem_ack) hold_word <= mem_rdata[15:0];
      else if ((st == ST_PER) && to_mem && pin_valid) hold_word <= pin_data;
      if (cmd_abort || run_end) chan_idle <= 1'b1;
      else if (start_acc)       chan_idle <= 1'b0;
    end
  end

  // port drive
  always_comb begin
    unique case (st)
      ST_F_CTL: mem_addr = cur_ptr;
      ST_F_BUF: mem_addr = cur_ptr + AW'(DESC_STRIDE);
      ST_F_NXT: mem_addr = cur_ptr + AW'(2 * DESC_STRIDE);
      default:  mem_addr = buf_addr;
    endcase
  end

  assign mem_req    = (st == ST_F_CTL) || (st == ST_F_BUF) || (st == ST_F_NXT) || (st == ST_MEM);
  assign mem_we     = (st == ST_MEM) && to_mem;
  assign mem_wdata  = hold_word;
  assign pout_valid = (st == ST_PER) && !to_mem;
  assign pout_data  = hold_word;
  assign pin_ready  = (st == ST_PER) && to_mem;

endmodule

// File: rtl/dwk_checker.sv
module dwk_checker
  import dwk_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BURST_LIMIT = 65536
) (
  input logic                             clk,
  input logic                             rst_n,
  input dwk_state_t                       st,
  input logic                             to_mem,
  input logic                             cmd_start,
  input logic                             cmd_abort,
  input logic                             chan_idle,
  input logic                             done_pulse,
  input logic                             mem_req,
  input logic                             mem_ack,
  input logic [AW-1:0]                    mem_addr,
  input logic                             pout_valid,
  input logic                             pout_ready,
  input logic [15:0]                      pout_data,
  input logic                             pin_ready,
  input logic [$clog2(BURST_LIMIT+1)-1:0] burst_cnt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chan_idle |-> (!mem_req && !pout_valid && !pin_ready)); // R1

  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_F_BUF) |-> ($past(st) == ST_F_CTL || $past(st) == ST_F_BUF)); // R2

  AST_DATA_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM || st == ST_PER) |->
      ($past(st) == ST_F_NXT || $past(st) == ST_MEM || $past(st) == ST_PER)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM && !to_mem && $past(st) == ST_PER) |->
      (mem_addr == $past(mem_addr) + AW'(2))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R7

  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> chan_idle); // R7

  AST_START_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_idle && cmd_start && !cmd_abort) |=> !chan_idle); // R7

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (chan_idle && !done_pulse)); // R8

  AST_BURST_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cnt <= ($clog2(BURST_LIMIT+1))'(BURST_LIMIT)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && !pout_ready && !cmd_abort) |=> (pout_valid && $stable(pout_data))); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cmd_abort) |=> (mem_req && $stable(mem_addr))); // R11

endmodule

bind dwk_walker dwk_checker #(.AW(AW), .BURST_LIMIT(BURST_LIMIT)) u_dwk_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .to_mem     (to_mem),
  .cmd_start  (cmd_start),
  .cmd_abort  (cmd_abort),
  .chan_idle  (chan_idle),
  .done_pulse (done_pulse),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .pout_valid (pout_valid),
  .pout_ready (pout_ready),
  .pout_data  (pout_data),
  .pin_ready  (pin_ready),
  .burst_cnt  (burst_cnt)
);

// File: tb/test_dwk_walker.sv
module test_dwk_walker;

  localparam int AW  = 32;
  localparam int LIM = 32800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ptr_wr = 1'b0;
  logic [31:0]   ptr_wdata = '0;
  logic          cmd_start = 1'b0, cmd_abort = 1'b0, dir_to_mem = 1'b0;
  logic          mem_req, mem_we, mem_ack;
  logic [31:0]   mem_addr, mem_rdata;
  logic [15:0]   mem_wdata;
  logic          pout_valid, pout_ready, pin_valid, pin_ready;
  logic [15:0]   pout_data, pin_data;
  logic          chan_idle, done_pulse;

  logic          stall = 1'b0, pin_on = 1'b0;
  logic [7:0]    cyc = '0;
  logic [15:0]   in_idx = '0;
  logic [31:0]   desc_mem [0:63];

  int total = 0, bad = 0;

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) cyc <= cyc + 8'd1;
  always @(posedge clk) if (pin_valid && pin_ready) in_idx <= in_idx + 16'd1;

  assign mem_ack    = mem_req && (!stall || cyc[0]);
  assign mem_rdata  = (mem_addr < 32'd256) ? desc_mem[mem_addr[7:2]] : {16'hBEEF, pat(mem_addr)};
  assign pout_ready = !stall || cyc[1];
  assign pin_valid  = pin_on && (!stall || cyc[1]);
  assign pin_data   = 16'h3000 + in_idx;

  dwk_walker #(.AW(AW), .BURST_LIMIT(LIM)) i_dwk_walker (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .cmd_start(cmd_start), .cmd_abort(cmd_abort), .dir_to_mem(dir_to_mem),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pout_valid(pout_valid), .pout_data(pout_data), .pout_ready(pout_ready),
    .pin_valid(pin_valid), .pin_data(pin_data), .pin_ready(pin_ready),
    .chan_idle(chan_idle), .done_pulse(done_pulse)
  );

  // expected-stream monitor
  logic [31:0] seg_base [0:3];
  int          seg_len  [0:3];
  int nseg = 0, m_seg = 0, m_off = 0, mv_cnt = 0, mis = 0, extra = 0, early = 0;
  int rd_cnt = 0, done_cnt = 0, dbl_done = 0, in_base = 0;
  logic [31:0] rd_log [0:31];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pulse) begin
        done_cnt++;
        if (prev_done) dbl_done++;
      end
      prev_done = done_pulse;
      if (mem_req && mem_ack && !mem_we && mem_addr < 32'd256) begin
        if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
      if ((pout_valid && pout_ready) || (mem_req && mem_ack && mem_we)) begin
        if (rd_cnt < 3) early++;
        if (m_seg >= nseg) extra++;
        else begin
          if (pout_valid) begin
            if (pout_data != pat(seg_base[m_seg] + 32'(2 * m_off))) mis++;
          end else begin
            if (mem_addr != seg_base[m_seg] + 32'(2 * m_off) ||
                mem_wdata != 16'h3000 + 16'(in_base + mv_cnt)) mis++;
          end
          m_off++;
          if (m_off == seg_len[m_seg]) begin m_seg++; m_off = 0; end
        end
        mv_cnt++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic put_desc(input logic [7:0] a, input logic [15:0] len, input logic eol,
                          input logic [31:0] b, input logic [31:0] nxt);
    desc_mem[a[7:2]]     = {15'd0, eol, len};
    desc_mem[a[7:2] + 1] = b;
    desc_mem[a[7:2] + 2] = nxt;
  endtask

  task automatic clear_mon(input int n);
    nseg = n; m_seg = 0; m_off = 0; mv_cnt = 0; mis = 0; extra = 0; early = 0;
    rd_cnt = 0; done_cnt = 0; dbl_done = 0; in_base = int'(in_idx);
  endtask

  task automatic load_ptr(input logic [31:0] p);
    ptr_wr = 1'b1; ptr_wdata = p; tick(); ptr_wr = 1'b0;
  endtask

  task automatic pulse_start();
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && !chan_idle; i++) tick();
    repeat (3) tick();
  endtask

  task automatic t_reset();
    chk("R1 idle after reset", chan_idle, 1);
    chk("R1 no done after reset", done_pulse, 0);
    chk("R1 no activity after reset", {mem_req, pout_valid, pin_ready}, 0);
  endtask

  task automatic t_single();
    put_desc(8'h40, 16'd8, 1'b1, 32'h1000, 32'h0);
    seg_base[0] = 32'h1000; seg_len[0] = 4;
    clear_mon(1); dir_to_mem = 1'b0; stall = 1'b0;
    load_ptr(32'h40); pulse_start();
    chk("R7 start clears idle", chan_idle, 0);
    wait_idle(200);
    chk("R2 fetch count", rd_cnt, 3);
    chk("R2 fetch ctl addr", rd_log[0], 32'h40);
    chk("R2 fetch buf addr", rd_log[1], 32'h44);
    chk("R2 fetch next addr", rd_log[2], 32'h48);
    chk("R2 no data before fetch", early, 0);
    chk("R3 word count len 8", mv_cnt, 4);
    chk("R4 outbound data mismatches", mis, 0);
    chk("R7 one done pulse", done_cnt, 1);
    chk("R7 done one cycle wide", dbl_done, 0);
    repeat (10) tick();
    chk("R7 idle sticky", chan_idle, 1);
    chk("R1 quiet while idle", {mem_req, pout_valid, pin_ready}, 0);
  endtask

  task automatic t_chain();
    put_desc(8'h00, 16'd6,  1'b0, 32'h2000, 32'h80);
    put_desc(8'h80, 16'd10, 1'b0, 32'h2400, 32'h20);
    put_desc(8'h20, 16'd4,  1'b1, 32'h2800, 32'hFC);
    seg_base[0] = 32'h2000; seg_len[0] = 3;
    seg_base[1] = 32'h2400; seg_len[1] = 5;
    seg_base[2] = 32'h2800; seg_len[2] = 2;
    clear_mon(3); dir_to_mem = 1'b0; stall = 1'b1;
    load_ptr(32'h00); pulse_start();
    wait_idle(400);
    stall = 1'b0;
    chk("R6 fetches for 3 descriptors", rd_cnt, 9);
    chk("R6 second desc from next ptr", rd_log[3], 32'h80);
    chk("R6 third desc from next ptr", rd_log[6], 32'h20);
    chk("R11 words under stalls", mv_cnt, 10);
    chk("R11 data order under stalls", mis, 0);
    chk("R11 no extra words", extra, 0);
    chk("R7 done after chain", done_cnt, 1);
  endtask

  task automatic t_inbound();
    put_desc(8'h60, 16'd12, 1'b1, 32'h3000, 32'h0);
    seg_base[0] = 32'h3000; seg_len[0] = 6;
    clear_mon(1); dir_to_mem = 1'b1; pin_on = 1'b1; stall = 1'b0;
    load_ptr(32'h60); pulse_start();
    dir_to_mem = 1'b0;
    wait_idle(200);
    pin_on = 1'b0;
    chk("R5 inbound words written", mv_cnt, 6);
    chk("R5 inbound addr/data mismatches", mis, 0);
    chk("R5 inbound done", done_cnt, 1);
  endtask

  task automatic t_abort();
    int snap;
    put_desc(8'hA0, 16'd400, 1'b1, 32'h6000, 32'h0);
    seg_base[0] = 32'h6000; seg_len[0] = 200;
    clear_mon(1); dir_to_mem = 1'b0;
    load_ptr(32'hA0); pulse_start();
    for (int i = 0; i < 200 && mv_cnt < 20; i++) tick();
    cmd_abort = 1'b1; tick(); cmd_abort = 1'b0;
    chk("R8 idle after abort", chan_idle, 1);
    snap = mv_cnt;
    repeat (40) tick();
    chk("R8 no words after abort", mv_cnt, snap);
    chk("R8 no done on abort", done_cnt, 0);
    chk("R8 quiet after abort", {mem_req, pout_valid, pin_ready}, 0);
    chk("R8 data before abort", mis, 0);
  endtask

  task automatic t_busy_cmds();
    put_desc(8'hC0, 16'd40, 1'b1, 32'h7000, 32'h0);
    put_desc(8'hD0, 16'd6,  1'b1, 32'h7800, 32'h0);
    seg_base[0] = 32'h7000; seg_len[0] = 20;
    seg_base[1] = 32'h7800; seg_len[1] = 3;
    clear_mon(2); dir_to_mem = 1'b0;
    load_ptr(32'hC0); pulse_start();
    repeat (5) tick();
    load_ptr(32'hD0); pulse_start();
    wait_idle(300);
    chk("R10 busy start ignored", mv_cnt, 20);
    chk("R10 run unaffected by ptr write", mis, 0);
    chk("R10 single done", done_cnt, 1);
    pulse_start();
    wait_idle(100);
    chk("R10 new ptr used at next start", rd_log[3], 32'hD0);
    chk("R10 second run words", mv_cnt, 23);
    chk("R10 second run data", mis, 0);
  endtask

  task automatic t_long_cap();
    put_desc(8'hE0, 16'd0,   1'b0, 32'h10000, 32'hF0);
    put_desc(8'hF0, 16'd200, 1'b1, 32'h40000, 32'h0);
    seg_base[0] = 32'h10000; seg_len[0] = 32768;
    seg_base[1] = 32'h40000; seg_len[1] = 32;
    clear_mon(2); dir_to_mem = 1'b0; stall = 1'b0;
    load_ptr(32'hE0); pulse_start();
    wait_idle(80000);
    chk("R3 zero length then chain fetch count", rd_cnt, 6);
    chk("R3 zero length data order", mis, 0);
    chk("R9 words capped", mv_cnt, LIM);
    chk("R9 nothing past cap", extra, 0);
    chk("R9 done at cap", done_cnt, 1);
    chk("R9 idle at cap", chan_idle, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) desc_mem[i] = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_chain();
    t_inbound();
    t_abort();
    t_busy_cmds();
    t_long_cap();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

endmodule